// File: doc/BRIEF.md
# Segmented Base-and-Bound Address Translator

This block turns an effective address into a physical address using segment relocation, and checks each access against the segment's limit. The effective address is split into a segment number (upper bits) and an offset (lower bits). The segment number picks one entry from a segment table. Each entry holds a base and a bound. The physical address is the base plus the offset. The access is legal only if that sum lies strictly below the entry's bound. If it does not, a violation is flagged and the physical address output is forced to zero.

Every execution context has its own segment table, and a context-select input chooses which table serves translation. The segment number can come from the address itself (explicit mode). It can also be implied by the kind of access (implicit mode): instruction fetches use segment 0 and data accesses use segment 1. Translation is purely combinational. The table is written through a configuration port that accepts writes only in supervisor mode. A write attempted in user mode is dropped and answered with a one-cycle privilege-error pulse.

Top module: `seg_xlate_top`

## Requirements
- R1: For a legal access, `phys_addr` equals the selected entry's base plus the zero-extended offset, in the same cycle as the inputs.
- R2: An access is legal only when base + offset, computed without truncation, is strictly less than the entry's bound. A sum equal to the bound, or a sum that carries past PA_W bits, raises `violation`.
- R3: Whenever `violation` is 1, `phys_addr` is 0.
- R4: When `implicit_mode` is 0, the segment number is `eff_addr[SEG_W+OFS_W-1:OFS_W]` and the offset is `eff_addr[OFS_W-1:0]`.
- R5: When `implicit_mode` is 1, the segment number is 0 if `is_fetch` is 1 and 1 if `is_fetch` is 0. The segment field of `eff_addr` is ignored, and the offset is still `eff_addr[OFS_W-1:0]`.
- R6: Each context value on `ctx_sel` has its own table. A write to an entry in one context leaves the entries of every other context unchanged.
- R7: A write with `cfg_we`=1 and `cfg_supervisor`=1 updates entry (`cfg_ctx`, `cfg_seg`) at the clock edge. A translation in the same cycle as the write still uses the old entry.
- R8: A write with `cfg_we`=1 and `cfg_supervisor`=0 leaves the table unchanged. It drives `priv_err` high for exactly the one cycle after the attempt. Supervisor writes never raise `priv_err`.
- R9: After reset, every entry has base 0 and bound 0, so every access is a violation, and `priv_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx_sel | input | CTX_W | Context whose table serves translation |
| eff_addr | input | SEG_W+OFS_W | Effective address: segment field above the offset |
| implicit_mode | input | 1 | 1: segment chosen by access kind; 0: segment taken from the address |
| is_fetch | input | 1 | 1 for an instruction fetch, 0 for a load or store |
| phys_addr | output | PA_W | Relocated address, 0 on violation |
| violation | output | 1 | Bound check failed |
| cfg_we | input | 1 | Table write request |
| cfg_supervisor | input | 1 | Requester is in supervisor mode |
| cfg_ctx | input | CTX_W | Context of the entry to write |
| cfg_seg | input | SEG_W | Segment of the entry to write |
| cfg_base | input | PA_W | New base |
| cfg_bound | input | PA_W | New bound |
| priv_err | output | 1 | One-cycle pulse after a rejected user-mode write |

## Verification
A table write and a translation that reads the same entry can fall in the same cycle. The bench drives a supervisor write to the context and segment being translated while it holds that address on the translate inputs. It samples the outputs before the clock edge and expects the old relocation. It samples again after the edge and expects the new one. A rejected user-mode write is also overlapped with an ongoing translation. The bench then checks that the privilege pulse appears and that the translation result does not change.

// File: rtl/seg_xlate_pkg.sv
// Package: shared constants for the segment translator.
// Assumes: code segment and data segment numbers fit in any SEG_W >= 1.
package seg_xlate_pkg;
    // Segment used for instruction fetches in implicit mode.
    localparam int unsigned CODE_SEG = 0;
    // Segment used for loads and stores in implicit mode.
    localparam int unsigned DATA_SEG = 1;
endpackage

// File: rtl/seg_table.sv
// Module: seg_table
// Holds one base/bound table per context. Writes are accepted only from
// supervisor mode; a user-mode attempt is dropped and answered with a
// one-cycle priv_err pulse. Reads are combinational.
// Assumes: synchronous active-low reset clears every entry to zero.
module seg_table #(
    parameter int SEG_W = 4,
    parameter int CTX_W = 2,
    parameter int PA_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_supervisor,
    input  logic [CTX_W-1:0] cfg_ctx,
    input  logic [SEG_W-1:0] cfg_seg,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [PA_W-1:0]  cfg_bound,
    input  logic [CTX_W-1:0] rd_ctx,
    input  logic [SEG_W-1:0] rd_seg,
    output logic [PA_W-1:0]  rd_base,
    output logic [PA_W-1:0]  rd_bound,
    output logic             priv_err
);
    localparam int IDX_W   = CTX_W + SEG_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [PA_W-1:0]  base_q  [ENTRIES];
    logic [PA_W-1:0]  bound_q [ENTRIES];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             wr_ok;
    logic             wr_bad;

    assign wr_idx = {cfg_ctx, cfg_seg};
    assign rd_idx = {rd_ctx, rd_seg};
    assign wr_ok  = cfg_we && cfg_supervisor;
    assign wr_bad = cfg_we && !cfg_supervisor;

    // Storage: clear on reset, update on a privileged write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                base_q[i]  <= '0;
                bound_q[i] <= '0;
            end
        end else if (wr_ok) begin
            base_q[wr_idx]  <= cfg_base;
            bound_q[wr_idx] <= cfg_bound;
        end
    end

    // Privilege error: registered pulse one cycle after a user write.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_err <= 1'b0;
        else        priv_err <= wr_bad;
    end

    // Read port: combinational lookup for translation.
    always_comb begin
        rd_base  = base_q[rd_idx];
        rd_bound = bound_q[rd_idx];
    end

    // R7: a supervisor write lands in the addressed entry.
    p_sup_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (base_q[$past(wr_idx)] == $past(cfg_base)) &&
                  (bound_q[$past(wr_idx)] == $past(cfg_bound)));

    // R8: a user write leaves the addressed entry untouched.
    p_user_write_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> (base_q[$past(wr_idx)] == $past(base_q[wr_idx])) &&
                   (bound_q[$past(wr_idx)] == $past(bound_q[wr_idx])));

    // R8: priv_err follows a rejected write and nothing else.
    p_priv_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> priv_err);
    p_priv_err_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_bad |=> !priv_err);
endmodule

// File: rtl/seg_select.sv
// Module: seg_select
// Chooses the segment number either from the address field or from the
// access kind, and extracts the offset.
// Assumes: SEG_W >= 1 so that segments 0 and 1 both exist.
module seg_select
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int OFS_W = 16
) (
    input  logic [SEG_W+OFS_W-1:0] eff_addr,
    input  logic                   implicit_mode,
    input  logic                   is_fetch,
    output logic [SEG_W-1:0]       seg_num,
    output logic [OFS_W-1:0]       seg_ofs
);
    localparam logic [SEG_W-1:0] CODE_NUM = SEG_W'(CODE_SEG);
    localparam logic [SEG_W-1:0] DATA_NUM = SEG_W'(DATA_SEG);

    // Segment choice: kind-implied or taken from the address field.
    always_comb begin
        seg_ofs = eff_addr[OFS_W-1:0];
        if (implicit_mode) seg_num = is_fetch ? CODE_NUM : DATA_NUM;
        else               seg_num = eff_addr[SEG_W+OFS_W-1:OFS_W];
    end
endmodule

// File: rtl/seg_check.sv
// Module: seg_check
// Adds the base to the offset without truncation and compares the result
// against the bound. Flags a violation and zeroes the output on failure.
// Assumes: PA_W >= OFS_W; clk/rst_n are used only by the assertions.
module seg_check #(
    parameter int OFS_W = 16,
    parameter int PA_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] seg_ofs,
    input  logic [PA_W-1:0]  seg_base,
    input  logic [PA_W-1:0]  seg_bound,
    output logic [PA_W-1:0]  phys_addr,
    output logic             violation
);
    localparam int SUM_W = PA_W + 1;

    logic [SUM_W-1:0] sum;
    logic             in_range;

    // Relocation and limit compare on the full-width relocated address.
    always_comb begin
        sum       = {1'b0, seg_base} + SUM_W'(seg_ofs);
        in_range  = sum < {1'b0, seg_bound};
        violation = !in_range;
        phys_addr = in_range ? sum[PA_W-1:0] : '0;
    end

    // R2: a legal result lies at or above the base and below the bound.
    p_legal_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !violation |-> (phys_addr < seg_bound) && (phys_addr >= seg_base));

    // R1: a legal result differs from the base by exactly the offset.
    p_offset_preserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !violation |-> (phys_addr - seg_base) == PA_W'(seg_ofs));
endmodule

// File: rtl/seg_xlate_top.sv
// Module: seg_xlate_top
// Segmented base-and-bound translator: segment selection, per-context
// table with privileged write port, and combinational relocate/check.
// Assumes: translation inputs are stable around the clock edge of a write.
module seg_xlate_top #(
    parameter int SEG_W = 4,
    parameter int OFS_W = 16,
    parameter int PA_W  = 24,
    parameter int CTX_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CTX_W-1:0]       ctx_sel,
    input  logic [SEG_W+OFS_W-1:0] eff_addr,
    input  logic                   implicit_mode,
    input  logic                   is_fetch,
    output logic [PA_W-1:0]        phys_addr,
    output logic                   violation,
    input  logic                   cfg_we,
    input  logic                   cfg_supervisor,
    input  logic [CTX_W-1:0]       cfg_ctx,
    input  logic [SEG_W-1:0]       cfg_seg,
    input  logic [PA_W-1:0]        cfg_base,
    input  logic [PA_W-1:0]        cfg_bound,
    output logic                   priv_err
);
    logic [SEG_W-1:0] seg_num;
    logic [OFS_W-1:0] seg_ofs;
    logic [PA_W-1:0]  sel_base;
    logic [PA_W-1:0]  sel_bound;

    seg_select #(.SEG_W(SEG_W), .OFS_W(OFS_W)) i_select (
        .eff_addr      (eff_addr),
        .implicit_mode (implicit_mode),
        .is_fetch      (is_fetch),
        .seg_num       (seg_num),
        .seg_ofs       (seg_ofs)
    );

    seg_table #(.SEG_W(SEG_W), .CTX_W(CTX_W), .PA_W(PA_W)) i_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_supervisor (cfg_supervisor),
        .cfg_ctx        (cfg_ctx),
        .cfg_seg        (cfg_seg),
        .cfg_base       (cfg_base),
        .cfg_bound      (cfg_bound),
        .rd_ctx         (ctx_sel),
        .rd_seg         (seg_num),
        .rd_base        (sel_base),
        .rd_bound       (sel_bound),
        .priv_err       (priv_err)
    );

    seg_check #(.OFS_W(OFS_W), .PA_W(PA_W)) i_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_ofs   (seg_ofs),
        .seg_base  (sel_base),
        .seg_bound (sel_bound),
        .phys_addr (phys_addr),
        .violation (violation)
    );

    // R3: a flagged access never exposes an address.
    p_zero_on_violation_r3: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> phys_addr == '0);
endmodule

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;
    localparam int SEG_W = 4;
    localparam int OFS_W = 16;
    localparam int PA_W  = 24;
    localparam int CTX_W = 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [CTX_W-1:0]       ctx_sel = '0;
    logic [SEG_W+OFS_W-1:0] eff_addr = '0;
    logic                   implicit_mode = 1'b0;
    logic                   is_fetch = 1'b0;
    logic [PA_W-1:0]        phys_addr;
    logic                   violation;
    logic                   cfg_we = 1'b0;
    logic                   cfg_supervisor = 1'b0;
    logic [CTX_W-1:0]       cfg_ctx = '0;
    logic [SEG_W-1:0]       cfg_seg = '0;
    logic [PA_W-1:0]        cfg_base = '0;
    logic [PA_W-1:0]        cfg_bound = '0;
    logic                   priv_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_xlate_top #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W), .CTX_W(CTX_W)) i_seg_xlate_top (
        .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .eff_addr(eff_addr),
        .implicit_mode(implicit_mode), .is_fetch(is_fetch),
        .phys_addr(phys_addr), .violation(violation),
        .cfg_we(cfg_we), .cfg_supervisor(cfg_supervisor), .cfg_ctx(cfg_ctx),
        .cfg_seg(cfg_seg), .cfg_base(cfg_base), .cfg_bound(cfg_bound),
        .priv_err(priv_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one table write; checks the privilege pulse it produces (R8).
    task automatic write_entry(bit sup, int ctx, int seg, int base, int bound);
        @(negedge clk);
        cfg_we = 1'b1; cfg_supervisor = sup;
        cfg_ctx = CTX_W'(ctx); cfg_seg = SEG_W'(seg);
        cfg_base = PA_W'(base); cfg_bound = PA_W'(bound);
        @(negedge clk);
        cfg_we = 1'b0;
        #1 check("R8 pulse", 32'(priv_err), 32'(!sup));
        @(negedge clk);
        #1 check("R8 pulse end", 32'(priv_err), 0);
    endtask

    // Apply a translation and compare both outputs.
    task automatic xlate(string req, int ctx, bit impl, bit fetch, int seg, int ofs,
                         bit exp_v, int exp_pa);
        @(negedge clk);
        ctx_sel = CTX_W'(ctx); implicit_mode = impl; is_fetch = fetch;
        eff_addr = {SEG_W'(seg), OFS_W'(ofs)};
        #1;
        check(req, 32'(violation), 32'(exp_v));
        check(req, 32'(phys_addr), 32'(exp_pa));
    endtask

    task automatic t_reset();
        // R9: cleared table, everything violates, R3 address zero
        xlate("R9 reset", 0, 1'b0, 1'b0, 0, 0, 1'b1, 0);
        xlate("R9 reset ctx3", 3, 1'b0, 1'b0, 15, 16'hFFFF, 1'b1, 0);
        check("R9 priv_err", 32'(priv_err), 0);
    endtask

    task automatic t_explicit();
        write_entry(1'b1, 0, 3, 'h100000, 'h100800);
        write_entry(1'b1, 0, 5, 'hABCD00, 'hFFFFFF);
        write_entry(1'b1, 0, 6, 'hFFFF00, 'hFFFFFF);
        xlate("R1 R4 last legal", 0, 1'b0, 1'b0, 3, 'h07FF, 1'b0, 'h1007FF);
        xlate("R2 equal bound", 0, 1'b0, 1'b0, 3, 'h0800, 1'b1, 0);
        xlate("R1 R4 seg5", 0, 1'b0, 1'b0, 5, 'h1234, 1'b0, 'hABDF34);
        xlate("R2 R3 carry", 0, 1'b0, 1'b0, 6, 'h0100, 1'b1, 0);
        xlate("R2 below max", 0, 1'b0, 1'b0, 6, 'h00FE, 1'b0, 'hFFFFFE);
    endtask

    task automatic t_implicit();
        write_entry(1'b1, 0, 0, 'h001000, 'h002000);
        write_entry(1'b1, 0, 1, 'h200000, 'h210000);
        xlate("R5 fetch", 0, 1'b1, 1'b1, 5, 'h0010, 1'b0, 'h001010);
        xlate("R5 data", 0, 1'b1, 1'b0, 5, 'h0010, 1'b0, 'h200010);
        xlate("R5 code limit", 0, 1'b1, 1'b1, 3, 'h1000, 1'b1, 0);
    endtask

    task automatic t_contexts();
        write_entry(1'b1, 1, 3, 'h050000, 'h060000);
        xlate("R6 ctx1", 1, 1'b0, 1'b0, 3, 'h07FF, 1'b0, 'h0507FF);
        xlate("R6 ctx0 kept", 0, 1'b0, 1'b0, 3, 'h07FF, 1'b0, 'h1007FF);
        xlate("R6 ctx2 empty", 2, 1'b0, 1'b0, 3, 'h07FF, 1'b1, 0);
    endtask

    task automatic t_same_cycle();
        // R7: write and translate the same entry in one cycle
        @(negedge clk);
        ctx_sel = '0; implicit_mode = 1'b0; eff_addr = {4'h3, 16'h0010};
        cfg_we = 1'b1; cfg_supervisor = 1'b1; cfg_ctx = '0; cfg_seg = 4'h3;
        cfg_base = 24'h300000; cfg_bound = 24'h310000;
        #1 check("R7 old value", 32'(phys_addr), 32'h100010);
        @(negedge clk);
        cfg_we = 1'b0;
        #1 check("R7 new value", 32'(phys_addr), 32'h300010);
        check("R7 no priv_err", 32'(priv_err), 0);
    endtask

    task automatic t_user_write();
        // R8: rejected write overlapped with translation of that entry
        write_entry(1'b0, 0, 3, 'h000000, 'hFFFFFF);
        xlate("R8 entry kept", 0, 1'b0, 1'b0, 3, 'h0010, 1'b0, 'h300010);
        xlate("R8 bound kept", 0, 1'b0, 1'b0, 3, 'h0000, 1'b0, 'h300000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_explicit();
        t_implicit();
        t_contexts();
        t_same_cycle();
        t_user_write();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule